// File: doc/BRIEF.md
# Character Display Parallel Bus Master

This block is the host side of an 8-bit parallel bus to a character display controller. The bus has a register-select line, a read/write line, an enable strobe and eight data lines. A client asks for a single transfer by giving the register select, the direction and, for a write, a byte. The block then runs one complete strobe cycle on the bus. When the transfer is over it raises a one-cycle completion pulse, and for a read it presents the byte it captured.

Every timing minimum of the bus is a parameter given in nanoseconds. A second parameter gives the clock period. Each minimum is turned into a whole number of clock cycles when the design is built. A state machine orders five phases: the select/direction setup, the enable-high strobe, the hold after the strobe falls, the recovery to the full enable cycle time, and idle. Writes and reads use different strobe lengths and different hold lengths. On a read, the strobe is stretched until the display's output delay has passed. The data-bus output enable is raised only for writes, so the host and the display never drive the bus at the same time.

Top module: `cdisp_bus_ctrl`

## Requirements
- R1: A request (`req_valid` high) is taken only when `busy` is low. `busy` is high from the clock after acceptance until the cycle in which `done` pulses. Requests made while `busy` is high start no strobe.
- R2: `lcd_rs` follows `req_rs`, where 1 selects the data register and 0 selects the instruction register on writes or the status byte on reads. `lcd_rw` follows `req_read`, where 1 is a read and 0 a write. Both are stable from at least `T_AS_NS` before `lcd_e` rises until at least `T_AH_NS` after it falls.
- R3: Every `lcd_e` high pulse lasts at least `T_PW_NS`.
- R4: Successive rising edges of `lcd_e` are at least `T_CYC_NS` apart. `busy` stays high until `T_CYC_NS` have passed since the last rising edge.
- R5: On a write, `lcd_db_out` carries the request byte with bit 7 on DB7 (MSB) and bit 0 on DB0. `lcd_db_oe` is high, and both hold steady from at least `T_DSW_NS` before `lcd_e` falls until at least `T_DHW_NS` after it falls.
- R6: On a read, `lcd_db_in` is sampled at the clock edge that drives `lcd_e` low. That edge is at least `T_DD_NS` after `lcd_e` rose, and the strobe is lengthened past `T_PW_NS` when needed.
- R7: `lcd_db_oe` is never high while `lcd_rw` is high. It is low during reads and out of reset.
- R8: `done` is a one-cycle pulse in the cycle `busy` falls. For a read, `rd_data` holds the captured byte in that cycle.
- R9: Each nanosecond minimum becomes a cycle count by ceiling division by `CLK_NS`, with a floor of one cycle. A minimum shorter than a clock therefore still takes one full clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request |
| req_rs | input | 1 | Register select for the request |
| req_read | input | 1 | 1 = read, 0 = write |
| req_wdata | input | DATA_W | Byte to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Byte captured by the last read |
| lcd_rs | output | 1 | Bus register select |
| lcd_rw | output | 1 | Bus direction, 1 = read |
| lcd_e | output | 1 | Bus enable strobe |
| lcd_db_out | output | DATA_W | Data driven onto the bus |
| lcd_db_oe | output | 1 | Output enable for `lcd_db_out` |
| lcd_db_in | input | DATA_W | Data read from the bus |

## Verification
The bench builds the block with a 10 ns clock. It lowers the pulse-width minimum to 60 ns, so the 100 ns read output delay, not the pulse width, sets the read strobe length; this brings the read stretch of R6 within reach. It also lowers the write data hold to 3 ns, so the one-cycle floor of R9 becomes visible. With these short strobes, the 400 ns cycle time is the longest constraint, so the recovery wait behind `busy` is exercised on every transfer. The display model checks every edge in nanoseconds. It presents read data only 99.9 ns after the strobe rises and drives the inverted byte before that, so a capture made one cycle early is caught.

// File: rtl/cdisp_pkg.sv
`timescale 1ns/1ps
package cdisp_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_RECOVER
    } phase_e;

    // ceiling division with a floor of one cycle
    function automatic int ns_to_cycles(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cdisp_span_timer.sv
`timescale 1ns/1ps
module cdisp_span_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] value_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = value_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/cdisp_read_latch.sv
`timescale 1ns/1ps
module cdisp_read_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic [DATA_W-1:0] data_o
);
    logic [DATA_W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (cap_i) data_d = bus_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign data_o = data_q;
endmodule

// File: rtl/cdisp_bus_ctrl.sv
`timescale 1ns/1ps
module cdisp_bus_ctrl #(
    parameter int DATA_W    = 8,
    parameter int CLK_NS    = 10,
    parameter int T_CYC_NS  = 400,
    parameter int T_PW_NS   = 150,
    parameter int T_AS_NS   = 30,
    parameter int T_AH_NS   = 10,
    parameter int T_DSW_NS  = 40,
    parameter int T_DHW_NS  = 10,
    parameter int T_DD_NS   = 100,
    parameter int T_DHR_NS  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_rs,
    input  logic              req_read,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              lcd_rs,
    output logic              lcd_rw,
    output logic              lcd_e,
    output logic [DATA_W-1:0] lcd_db_out,
    output logic              lcd_db_oe,
    input  logic [DATA_W-1:0] lcd_db_in
);
    import cdisp_pkg::*;

    // R9: cycle counts, ceiling rounded, at least one
    localparam int AS_C   = ns_to_cycles(T_AS_NS,  CLK_NS);
    localparam int AH_C   = ns_to_cycles(T_AH_NS,  CLK_NS);
    localparam int PW_C   = ns_to_cycles(T_PW_NS,  CLK_NS);
    localparam int DSW_C  = ns_to_cycles(T_DSW_NS, CLK_NS);
    localparam int DHW_C  = ns_to_cycles(T_DHW_NS, CLK_NS);
    localparam int DD_C   = ns_to_cycles(T_DD_NS,  CLK_NS);
    localparam int DHR_C  = ns_to_cycles(T_DHR_NS, CLK_NS);
    localparam int CYC_C  = ns_to_cycles(T_CYC_NS, CLK_NS);

    localparam int HI_W_C   = imax(PW_C, DSW_C);
    localparam int HI_R_C   = imax(PW_C, DD_C);
    localparam int HOLD_W_C = imax(AH_C, DHW_C);
    localparam int HOLD_R_C = imax(AH_C, DHR_C);
    localparam int PH_MAX   = imax(imax(AS_C, imax(HI_W_C, HI_R_C)), imax(HOLD_W_C, HOLD_R_C));
    localparam int PH_W     = $clog2(PH_MAX + 1);
    localparam int CY_W     = $clog2(CYC_C + 1);

    typedef struct packed {
        phase_e            ph;
        logic              rs;
        logic              rw;
        logic              e;
        logic [DATA_W-1:0] dout;
        logic              oe;
        logic              done;
    } regs_t;

    regs_t            r_d, r_q;
    logic             ph_load, ph_exp;
    logic [PH_W-1:0]  ph_val;
    logic             cy_load, cy_exp;
    logic             cap;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        ph_load  = 1'b0;
        ph_val   = '0;
        cy_load  = 1'b0;
        cap      = 1'b0;
        unique case (r_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    r_d.ph   = PH_SETUP;
                    r_d.rs   = req_rs;
                    r_d.rw   = req_read;
                    r_d.dout = req_wdata;
                    r_d.oe   = !req_read;
                    ph_load  = 1'b1;
                    ph_val   = PH_W'(AS_C - 1);
                end
            end
            PH_SETUP: begin
                if (ph_exp) begin
                    r_d.ph  = PH_STROBE;
                    r_d.e   = 1'b1;
                    ph_load = 1'b1;
                    ph_val  = r_q.rw ? PH_W'(HI_R_C - 1) : PH_W'(HI_W_C - 1);
                    cy_load = 1'b1;
                end
            end
            PH_STROBE: begin
                if (ph_exp) begin
                    r_d.ph  = PH_HOLD;
                    r_d.e   = 1'b0;
                    cap     = r_q.rw;
                    ph_load = 1'b1;
                    ph_val  = r_q.rw ? PH_W'(HOLD_R_C - 1) : PH_W'(HOLD_W_C - 1);
                end
            end
            PH_HOLD: begin
                if (ph_exp) begin
                    r_d.ph = PH_RECOVER;
                    r_d.rs = 1'b0;
                    r_d.rw = 1'b0;
                    r_d.oe = 1'b0;
                end
            end
            PH_RECOVER: begin
                if (cy_exp) begin
                    r_d.ph   = PH_IDLE;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.ph   <= PH_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    cdisp_span_timer #(.W(PH_W)) u_phase_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (ph_load),
        .value_i   (ph_val),
        .expired_o (ph_exp)
    );

    cdisp_span_timer #(.W(CY_W)) u_cycle_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (cy_load),
        .value_i   (CY_W'(CYC_C - 1)),
        .expired_o (cy_exp)
    );

    cdisp_read_latch #(.DATA_W(DATA_W)) u_rd_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (cap),
        .bus_i  (lcd_db_in),
        .data_o (rd_data)
    );

    assign busy       = (r_q.ph != PH_IDLE);
    assign done       = r_q.done;
    assign lcd_rs     = r_q.rs;
    assign lcd_rw     = r_q.rw;
    assign lcd_e      = r_q.e;
    assign lcd_db_out = r_q.dout;
    assign lcd_db_oe  = r_q.oe;
endmodule

// File: rtl/cdisp_bus_checks.sv
`timescale 1ns/1ps
module cdisp_bus_checks #(
    parameter int DATA_W   = 8,
    parameter int CLK_NS   = 10,
    parameter int T_PW_NS  = 150,
    parameter int T_CYC_NS = 400
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              done,
    input logic              lcd_rs,
    input logic              lcd_rw,
    input logic              lcd_e,
    input logic [DATA_W-1:0] lcd_db_out,
    input logic              lcd_db_oe
);
    localparam int PW_C  = cdisp_pkg::ns_to_cycles(T_PW_NS,  CLK_NS);
    localparam int CYC_C = cdisp_pkg::ns_to_cycles(T_CYC_NS, CLK_NS);
    localparam int HW    = $clog2(PW_C + 1);
    localparam int SW    = $clog2(CYC_C + 1);

    logic [HW-1:0] hi_q;
    logic [SW-1:0] since_q;
    logic          e_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q     <= '0;
            since_q  <= SW'(CYC_C);
            e_prev_q <= 1'b0;
        end else begin
            e_prev_q <= lcd_e;
            if (!lcd_e)                hi_q <= '0;
            else if (hi_q < HW'(PW_C)) hi_q <= hi_q + 1'b1;
            if (lcd_e && !e_prev_q)        since_q <= SW'(1);
            else if (since_q < SW'(CYC_C)) since_q <= since_q + 1'b1;
        end
    end

    assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);
    assert_strobe_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_e |-> busy);
    assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_e && e_prev_q) |-> ($stable(lcd_rs) && $stable(lcd_rw)));
    assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcd_e && e_prev_q) |-> (hi_q >= HW'(PW_C)));
    assert_cycle_time_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_e && !e_prev_q) |-> (since_q >= SW'(CYC_C)));
    assert_wdata_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_e && lcd_db_oe) |=> ($stable(lcd_db_out) && lcd_db_oe));
    assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_db_oe |-> !lcd_rw);
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !req_valid) |=> (busy || done));
endmodule

bind cdisp_bus_ctrl cdisp_bus_checks #(
    .DATA_W   (DATA_W),
    .CLK_NS   (CLK_NS),
    .T_PW_NS  (T_PW_NS),
    .T_CYC_NS (T_CYC_NS)
) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .busy       (busy),
    .done       (done),
    .lcd_rs     (lcd_rs),
    .lcd_rw     (lcd_rw),
    .lcd_e      (lcd_e),
    .lcd_db_out (lcd_db_out),
    .lcd_db_oe  (lcd_db_oe)
);

// File: tb/cdisp_bus_ctrl_test.sv
`timescale 1ns/1ps
module cdisp_bus_ctrl_test;
    localparam int CLK_NS   = 10;
    localparam int T_CYC_NS = 400;
    localparam int T_PW_NS  = 60;
    localparam int T_AS_NS  = 30;
    localparam int T_AH_NS  = 10;
    localparam int T_DSW_NS = 40;
    localparam int T_DHW_NS = 3;
    localparam int T_DD_NS  = 100;
    localparam int T_DHR_NS = 20;
    localparam logic [7:0] STATUS_BYTE = 8'h3C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic       req_valid = 1'b0, req_rs = 1'b0, req_read = 1'b0;
    logic [7:0] req_wdata = 8'h00;
    logic       busy, done, lcd_rs, lcd_rw, lcd_e, lcd_db_oe;
    logic [7:0] rd_data, lcd_db_out;
    logic [7:0] db_in = 8'h00;

    cdisp_bus_ctrl #(
        .DATA_W(8), .CLK_NS(CLK_NS), .T_CYC_NS(T_CYC_NS), .T_PW_NS(T_PW_NS),
        .T_AS_NS(T_AS_NS), .T_AH_NS(T_AH_NS), .T_DSW_NS(T_DSW_NS),
        .T_DHW_NS(T_DHW_NS), .T_DD_NS(T_DD_NS), .T_DHR_NS(T_DHR_NS)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rs(req_rs),
        .req_read(req_read), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e),
        .lcd_db_out(lcd_db_out), .lcd_db_oe(lcd_db_oe), .lcd_db_in(db_in)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    typedef struct packed {
        logic       rs;
        logic       rd;
        logic [7:0] data;
    } item_t;

    item_t bus_q[$];
    item_t rsp_q[$];

    logic [7:0] model_dreg = 8'h00;
    logic [7:0] model_ireg = 8'h00;
    logic [7:0] shadow_dreg = 8'h00;
    realtime t_addr = -1.0e6, t_data = -1.0e6, t_rise = -1.0e6, t_fall = -1.0e6;
    int  e_rises = 0;
    bit  last_was_write = 1'b0;

    // display-side model: address timing
    always @(lcd_rs or lcd_rw) begin
        if (rst_n) begin
            if (lcd_e)
                check(1'b0, "R2", "select/direction moved with E high", 1, 0);
            else if ($realtime - t_fall < T_AH_NS)
                check(1'b0, "R2", "select/direction hold after E fall",
                      int'($realtime - t_fall), T_AH_NS);
        end
        t_addr = $realtime;
    end

    always @(lcd_db_oe or lcd_rw) begin
        if (lcd_db_oe && lcd_rw)
            check(1'b0, "R7", "output enable high during read", 1, 0);
    end

    always @(lcd_db_out or lcd_db_oe) begin
        if (rst_n && last_was_write) begin
            if (lcd_e)
                check(1'b0, "R5", "write data moved with E high", 1, 0);
            else if ($realtime - t_fall < CLK_NS)
                check(1'b0, "R9", "write data hold below one clock",
                      int'($realtime - t_fall), CLK_NS);
        end
        t_data = $realtime;
    end

    always @(posedge lcd_e) begin
        if (rst_n) begin
            e_rises++;
            check($realtime - t_addr >= T_AS_NS, "R2", "address setup ns",
                  int'($realtime - t_addr), T_AS_NS);
            if (t_rise > -1.0e5)
                check($realtime - t_rise >= T_CYC_NS, "R4", "E cycle ns",
                      int'($realtime - t_rise), T_CYC_NS);
            t_rise = $realtime;
        end
    end

    // display drives read data at the worst-case output delay
    always @(posedge lcd_e) begin
        if (lcd_rw) begin
            logic [7:0] b;
            b = lcd_rs ? model_dreg : STATUS_BYTE;
            db_in = ~b;
            #(T_DD_NS - 0.1) db_in = b;
        end
    end

    always @(negedge lcd_e) begin
        if (lcd_rw) begin
            #(T_DHR_NS) db_in = ~db_in;
        end
    end

    always @(negedge lcd_e) begin
        if (rst_n) begin
            item_t it;
            check($realtime - t_rise >= T_PW_NS, "R3", "E pulse width ns",
                  int'($realtime - t_rise), T_PW_NS);
            if (bus_q.size() == 0) begin
                check(1'b0, "R1", "strobe with no accepted request", 1, 0);
            end else begin
                it = bus_q.pop_front();
                check(lcd_rs == it.rs, "R2", "register select", lcd_rs, it.rs);
                check(lcd_rw == it.rd, "R2", "direction", lcd_rw, it.rd);
                if (!it.rd) begin
                    check(lcd_db_oe == 1'b1, "R5", "output enable on write", lcd_db_oe, 1);
                    check(lcd_db_out == it.data, "R5", "write byte", lcd_db_out, it.data);
                    check($realtime - t_data >= T_DSW_NS, "R5", "write data setup ns",
                          int'($realtime - t_data), T_DSW_NS);
                    if (lcd_rs) model_dreg = lcd_db_out;
                    else        model_ireg = lcd_db_out;
                    last_was_write = 1'b1;
                end else begin
                    check($realtime - t_rise >= T_DD_NS, "R6", "read strobe stretched ns",
                          int'($realtime - t_rise), T_DD_NS);
                    last_was_write = 1'b0;
                end
            end
            t_fall = $realtime;
        end
    end

    // scoreboard monitor for completions
    always @(negedge clk) begin
        if (rst_n && done) begin
            item_t it;
            check(busy == 1'b0, "R8", "busy low with done", busy, 0);
            check($realtime - t_rise >= T_CYC_NS, "R4", "busy covers cycle time ns",
                  int'($realtime - t_rise), T_CYC_NS);
            if (rsp_q.size() == 0) begin
                check(1'b0, "R8", "done with no pending request", 1, 0);
            end else begin
                it = rsp_q.pop_front();
                if (it.rd)
                    check(rd_data == it.data, "R6", "read byte", rd_data, it.data);
            end
        end
    end

    task automatic xfer(input logic rs, input logic rd, input logic [7:0] wdata, input bit stray);
        item_t it;
        logic [7:0] exp;
        @(negedge clk);
        while (busy) @(negedge clk);
        exp = rd ? (rs ? shadow_dreg : STATUS_BYTE) : wdata;
        if (!rd && rs) shadow_dreg = wdata;
        it = '{rs: rs, rd: rd, data: exp};
        bus_q.push_back(it);
        rsp_q.push_back(it);
        req_rs = rs; req_read = rd; req_wdata = wdata; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R1", "busy after accept", busy, 1);
        if (stray) begin
            // R1: requests while busy must start nothing
            req_rs = ~rs; req_read = ~rd; req_wdata = ~wdata; req_valid = 1'b1;
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(busy == 1'b0, "R1", "busy in reset", busy, 0);
        check(lcd_e == 1'b0, "R3", "E in reset", lcd_e, 0);
        check(lcd_db_oe == 1'b0, "R7", "output enable in reset", lcd_db_oe, 0);
        check(done == 1'b0, "R8", "done in reset", done, 0);
        rst_n = 1'b1;
        xfer(1'b1, 1'b0, 8'hA5, 1'b0);
        xfer(1'b1, 1'b1, 8'h00, 1'b0);
        xfer(1'b0, 1'b0, 8'h01, 1'b1);
        xfer(1'b0, 1'b1, 8'h00, 1'b0);
        xfer(1'b1, 1'b0, 8'h80, 1'b0);
        xfer(1'b1, 1'b1, 8'h00, 1'b0);
        xfer(1'b1, 1'b1, 8'h00, 1'b1);
        xfer(1'b1, 1'b0, 8'h01, 1'b0);
        xfer(1'b1, 1'b1, 8'h00, 1'b0);
        while (rsp_q.size() != 0 || busy) @(negedge clk);
        repeat (5) @(negedge clk);
        check(bus_q.size() == 0, "R1", "strobes left pending", bus_q.size(), 0);
        check(e_rises == 9, "R1", "strobe count with stray requests", e_rises, 9);
        check(model_ireg == 8'h01, "R2", "instruction register write", model_ireg, 8'h01);
        check(model_dreg == 8'h01, "R5", "data register last write", model_dreg, 8'h01);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule